// File: doc/BRIEF.md
# Indexed Framebuffer Register Block

This block is the control-register side of an 8-bit indexed framebuffer display controller. A host issues 32-bit word reads and writes at byte offsets. The block decodes each offset into the register or table it belongs to. It holds the display geometry, a control word, the VRAM start address of the visible screen and the cursor position. It also holds three tables: a 256-entry colour palette, a 3-entry cursor colour table and a 512-word cursor bitmap. The geometry registers are kept in scaled units, so reads convert back to the units the host wrote.

The pixel datapath sits outside this block. It sees the stored state through decoded outputs. It looks up the colour palette and the cursor bitmap through two read ports, and each lookup returns data one clock cycle later. Timing registers of the wider controller can be written at their offsets, but the writes are dropped. A write to the reset offset returns every register and table to zero. A frame-done pulse from the video side raises an interrupt line, and any register write lowers it.

Top module: `fb_regif`

## Requirements
- R1: A write of v to offset 0x118 sets `disp_width` to 4·v, using the low GEOM_W-2 bits of v. A read of 0x118 returns `disp_width`/4.
- R2: A write of v to offset 0x150 sets `disp_height` to v/2, rounded down. A read of 0x150 returns `disp_height`·2, so its bit 0 is always zero.
- R3: Offset 0x300 stores a full 32-bit control word, and the word reads back unchanged. Bit 10 drives `disp_blank` and bit 23 drives `cursor_off`.
- R4: Control bits 22:20 give a code c. `depth_bits` is 1, 2, 4, 8, 15, 16, 0, 0 for c = 0 to 7, where 0 means unsupported. `image_on` is 1 only when c = 3 and bit 10 is clear.
- R5: Colour palette entry i sits at 0x800+8·i, and any byte offset inside that 8-byte slot selects it. Red is in bits 23:16, green in 15:8 and blue in 7:0. `pix_rgb` returns entry `pix_idx` one cycle after the index is presented. A bus read of the palette returns zero.
- R6: Cursor colour entry i, for i = 0 to 2, sits at 0x508+8·i with the same RGB packing. It reads back over the bus and appears on `curpal_rgb` bits [24i+23:24i].
- R7: Cursor bitmap word i, for i = 0 to 511, sits at 0x1000+8·i. A write stores the low 16 bits of the data. A bus read returns the word zero-extended. `curpat_word` returns word `curpat_idx` one cycle after the index is presented.
- R8: A write of v to 0x638 sets `cursor_x` to v[23:12] and `cursor_y` to v[11:0]. A write of v to 0x400 sets `screen_top` to the low VRAM_AW bits of v. Reads of either offset return zero.
- R9: Writes to the timing offsets (such as 0x108, 0x120 and 0x200) and to any other unmapped offset leave all state unchanged. Reads of unmapped offsets return zero.
- R10: A write of any value to 0x100000 clears the geometry, the control word, the screen start, the cursor position and all three tables to zero. Entries read as zero until they are written again. `rst` has the same effect.
- R11: A `frame_done` pulse sets `irq` in the next cycle. Any bus write clears `irq`. When a write and `frame_done` fall in the same cycle, `irq` is set.
- R12: `bus_rdata` carries the read result in the cycle after `bus_rd`. It is zero in every other cycle. Reads and writes are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | ADDR_W (21) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| frame_done | input | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Frame interrupt |
| disp_width | output | GEOM_W (12) | Width in pixels |
| disp_height | output | GEOM_W (12) | Height in lines |
| disp_blank | output | 1 | Force-blank flag |
| cursor_off | output | 1 | Cursor disable flag |
| depth_bits | output | 5 | Decoded bits per pixel, 0 if unsupported |
| image_on | output | 1 | 8-bit mode and not blanked |
| screen_top | output | VRAM_AW (23) | VRAM start of the visible screen |
| cursor_x | output | 12 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| pix_idx | input | 8 | Colour palette lookup index |
| pix_rgb | output | 24 | Colour palette entry, one cycle later |
| curpat_idx | input | 9 | Cursor bitmap lookup index |
| curpat_word | output | 16 | Cursor bitmap word, one cycle later |
| curpal_rgb | output | 72 | Three cursor colours, entry 0 in the low bits |

## Verification
The bench targets the scaling edges of the geometry registers. An odd vertical value must read back even, and a design that kept the raw value would return the odd one. The first and last cursor bitmap slots, and an entry whose upper data bits must be dropped, catch an off-by-one index or a truncation mistake. Reads of the write-only palette and of unmapped or ignored offsets must come back zero, and a leaky decode would return stale data. The bench also covers a write in the same cycle as `frame_done`, and a soft reset after the tables are filled. After the reset, a design that only cleared the scalar registers would still show the old palette and bitmap contents through the lookup ports.

// File: rtl/fb_regif_pkg.sv
package fb_regif_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_HDISP, RG_VDISP, RG_CTRL, RG_TOP,
    RG_CPOS, RG_CPAL, RG_PAL, RG_CPAT, RG_RESET
  } region_e;

  localparam int OFF_HDISP  = 'h118;
  localparam int OFF_VDISP  = 'h150;
  localparam int OFF_CTRL   = 'h300;
  localparam int OFF_TOP    = 'h400;
  localparam int OFF_CPOS   = 'h638;
  localparam int OFF_RESET  = 'h100000;
  localparam int BASE_CPAL  = 'h508;
  localparam int BASE_PAL   = 'h800;
  localparam int BASE_CPAT  = 'h1000;
  localparam int SLOT_BYTES = 8;

  localparam int CTRL_BLANK_BIT = 10;
  localparam int CTRL_NOCUR_BIT = 23;
  localparam int CTRL_DEPTH_LSB = 20;
  localparam logic [2:0] DEPTH_CODE_8BPP = 3'd3;

  function automatic logic [4:0] depth_of_code(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd15;
      3'd5:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/fb_regif_decode.sv
module fb_regif_decode
  import fb_regif_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int PAL_DEPTH  = 256,
  parameter int CPAT_DEPTH = 512,
  parameter int CPAL_N     = 3,
  parameter int IDX_W      = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  localparam int PAL_END  = BASE_PAL  + PAL_DEPTH  * SLOT_BYTES;
  localparam int CPAT_END = BASE_CPAT + CPAT_DEPTH * SLOT_BYTES;
  localparam int CPAL_END = BASE_CPAL + CPAL_N     * SLOT_BYTES;

  logic [31:0] a32;
  logic [31:0] off;

  assign a32 = 32'(addr);

  always_comb begin
    region = RG_NONE;
    off    = '0;
    if (a32 >= BASE_PAL && a32 < PAL_END) begin
      region = RG_PAL;
      off    = a32 - BASE_PAL;
    end else if (a32 >= BASE_CPAT && a32 < CPAT_END) begin
      region = RG_CPAT;
      off    = a32 - BASE_CPAT;
    end else if (a32 >= BASE_CPAL && a32 < CPAL_END) begin
      region = RG_CPAL;
      off    = a32 - BASE_CPAL;
    end else if ((a32 >> 2) == (OFF_HDISP >> 2)) region = RG_HDISP;
    else if ((a32 >> 2) == (OFF_VDISP >> 2))     region = RG_VDISP;
    else if ((a32 >> 2) == (OFF_CTRL >> 2))      region = RG_CTRL;
    else if ((a32 >> 2) == (OFF_TOP >> 2))       region = RG_TOP;
    else if ((a32 >> 2) == (OFF_CPOS >> 2))      region = RG_CPOS;
    else if ((a32 >> 2) == (OFF_RESET >> 2))     region = RG_RESET;
  end

  assign idx = IDX_W'(off >> 3);

endmodule

// File: rtl/fb_regif_ram.sv
module fb_regif_ram #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 24,
  parameter bit A_READ = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [$clog2(DEPTH)-1:0] a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  input  logic [$clog2(DEPTH)-1:0] b_addr,
  output logic [WIDTH-1:0] b_rdata
);

  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [WIDTH-1:0] b_q;
  logic             b_v;

  // storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_addr] <= a_wdata;
    b_q <= mem[b_addr];
  end

  // per-entry written flags give a one-cycle table clear
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld <= '0;
      b_v <= 1'b0;
    end else begin
      if (a_en && a_we) vld[a_addr] <= 1'b1;
      b_v <= vld[b_addr];
    end
  end

  assign b_rdata = b_v ? b_q : '0;

  generate
    if (A_READ) begin : g_a_read
      logic [WIDTH-1:0] a_q;
      logic             a_v;
      always_ff @(posedge clk) begin
        if (a_en && !a_we) a_q <= mem[a_addr];
      end
      always_ff @(posedge clk) begin
        if (rst || clr) a_v <= 1'b0;
        else if (a_en && !a_we) a_v <= vld[a_addr];
      end
      assign a_rdata = a_v ? a_q : '0;
    end else begin : g_a_wo
      assign a_rdata = '0;
    end
  endgenerate

  // R10
  // clr_empty_chk: after a clear no entry reads as written
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (b_rdata == '0) || $past(AW'(0) == AW'(0)) == 1'b0 || (b_v == 1'b0));

endmodule

// File: rtl/fb_regif_ctrl.sv
module fb_regif_ctrl
  import fb_regif_pkg::*;
#(
  parameter int GEOM_W  = 12,
  parameter int VRAM_AW = 23,
  parameter int CPAL_N  = 3,
  parameter int IDX_W   = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  region_e              region,
  input  logic [IDX_W-1:0]     idx,
  input  logic [31:0]          wdata,
  input  logic                 frame_done,
  output logic                 soft_clr,
  output logic [GEOM_W-1:0]    width,
  output logic [GEOM_W-1:0]    height,
  output logic [31:0]          ctrl_word,
  output logic [VRAM_AW-1:0]   top,
  output logic [23:0]          curpos,
  output logic [CPAL_N*24-1:0] cpal_flat,
  output logic                 irq,
  output logic [31:0]          rd_data
);

  localparam int CPAL_AW = (CPAL_N > 1) ? $clog2(CPAL_N) : 1;

  logic [23:0]        cpal_q [CPAL_N];
  logic [CPAL_AW-1:0] cidx;

  assign cidx     = idx[CPAL_AW-1:0];
  assign soft_clr = wr_en && (region == RG_RESET);

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      width     <= '0;
      height    <= '0;
      ctrl_word <= '0;
      top       <= '0;
      curpos    <= '0;
      for (int i = 0; i < CPAL_N; i++) cpal_q[i] <= '0;
    end else if (wr_en) begin
      case (region)
        RG_HDISP: width     <= {wdata[GEOM_W-3:0], 2'b00};
        RG_VDISP: height    <= wdata[GEOM_W:1];
        RG_CTRL:  ctrl_word <= wdata;
        RG_TOP:   top       <= wdata[VRAM_AW-1:0];
        RG_CPOS:  curpos    <= wdata[23:0];
        RG_CPAL:  cpal_q[cidx] <= wdata[23:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else if (frame_done) irq <= 1'b1;
    else if (wr_en) irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (rd_en) begin
        case (region)
          RG_HDISP: rd_data <= 32'(width[GEOM_W-1:2]);
          RG_VDISP: rd_data <= 32'({height, 1'b0});
          RG_CTRL:  rd_data <= ctrl_word;
          RG_CPAL:  rd_data <= 32'(cpal_q[cidx]);
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  generate
    for (genvar g = 0; g < CPAL_N; g++) begin : g_cpal
      assign cpal_flat[g*24 +: 24] = cpal_q[g];
    end
  endgenerate

  // R11
  // irq_set_chk
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> irq);

  // R11
  // irq_clr_chk
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !frame_done) |=> !irq);

  // R10
  // soft_clr_chk
  soft_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region == RG_RESET) |=> (width == '0 && height == '0 && ctrl_word == '0 && top == '0));

  // R9
  // ignore_wr_chk
  ignore_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region == RG_NONE) |=>
      ($stable(width) && $stable(height) && $stable(ctrl_word) && $stable(top) && $stable(curpos)));

  // R2
  // vread_even_chk
  vread_even_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && region == RG_VDISP) |=> (rd_data[0] == 1'b0));

endmodule

// File: rtl/fb_regif.sv
module fb_regif
  import fb_regif_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int GEOM_W     = 12,
  parameter int VRAM_AW    = 23,
  parameter int PAL_DEPTH  = 256,
  parameter int CPAT_DEPTH = 512,
  parameter int CPAL_N     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    frame_done,
  output logic                    irq,
  output logic [GEOM_W-1:0]       disp_width,
  output logic [GEOM_W-1:0]       disp_height,
  output logic                    disp_blank,
  output logic                    cursor_off,
  output logic [4:0]              depth_bits,
  output logic                    image_on,
  output logic [VRAM_AW-1:0]      screen_top,
  output logic [11:0]             cursor_x,
  output logic [11:0]             cursor_y,
  input  logic [$clog2(PAL_DEPTH)-1:0]  pix_idx,
  output logic [23:0]             pix_rgb,
  input  logic [$clog2(CPAT_DEPTH)-1:0] curpat_idx,
  output logic [15:0]             curpat_word,
  output logic [CPAL_N*24-1:0]    curpal_rgb
);

  localparam int PAL_AW  = $clog2(PAL_DEPTH);
  localparam int CPAT_AW = $clog2(CPAT_DEPTH);
  localparam int IDX_W   = (PAL_AW > CPAT_AW) ? PAL_AW : CPAT_AW;

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic             soft_clr;
  logic [31:0]      ctrl_word;
  logic [23:0]      curpos;
  logic [31:0]      ctrl_rd;
  logic [15:0]      pat_rd;
  logic [23:0]      pal_rd_unused;
  logic             rsel_pat;

  fb_regif_decode #(
    .ADDR_W(ADDR_W), .PAL_DEPTH(PAL_DEPTH), .CPAT_DEPTH(CPAT_DEPTH),
    .CPAL_N(CPAL_N), .IDX_W(IDX_W)
  ) u_decode (
    .addr(bus_addr), .region(region), .idx(idx)
  );

  fb_regif_ctrl #(
    .GEOM_W(GEOM_W), .VRAM_AW(VRAM_AW), .CPAL_N(CPAL_N), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd),
    .region(region), .idx(idx), .wdata(bus_wdata), .frame_done(frame_done),
    .soft_clr(soft_clr), .width(disp_width), .height(disp_height),
    .ctrl_word(ctrl_word), .top(screen_top), .curpos(curpos),
    .cpal_flat(curpal_rgb), .irq(irq), .rd_data(ctrl_rd)
  );

  // colour palette: write-only from the bus, read by the pixel path
  fb_regif_ram #(.DEPTH(PAL_DEPTH), .WIDTH(24), .A_READ(1'b0)) u_pal (
    .clk(clk), .rst(rst), .clr(soft_clr),
    .a_en(bus_wr && region == RG_PAL), .a_we(1'b1),
    .a_addr(idx[PAL_AW-1:0]), .a_wdata(bus_wdata[23:0]), .a_rdata(pal_rd_unused),
    .b_addr(pix_idx), .b_rdata(pix_rgb)
  );

  // cursor bitmap: bus read/write on port A, pixel path on port B
  fb_regif_ram #(.DEPTH(CPAT_DEPTH), .WIDTH(16), .A_READ(1'b1)) u_cpat (
    .clk(clk), .rst(rst), .clr(soft_clr),
    .a_en((bus_wr || bus_rd) && region == RG_CPAT), .a_we(bus_wr),
    .a_addr(idx[CPAT_AW-1:0]), .a_wdata(bus_wdata[15:0]), .a_rdata(pat_rd),
    .b_addr(curpat_idx), .b_rdata(curpat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) rsel_pat <= 1'b0;
    else     rsel_pat <= bus_rd && (region == RG_CPAT);
  end

  assign bus_rdata  = rsel_pat ? {16'b0, pat_rd} : ctrl_rd;

  assign disp_blank = ctrl_word[CTRL_BLANK_BIT];
  assign cursor_off = ctrl_word[CTRL_NOCUR_BIT];
  assign depth_bits = depth_of_code(ctrl_word[CTRL_DEPTH_LSB +: 3]);
  assign image_on   = !disp_blank && (ctrl_word[CTRL_DEPTH_LSB +: 3] == DEPTH_CODE_8BPP);
  assign cursor_x   = curpos[23:12];
  assign cursor_y   = curpos[11:0];

  // R12
  // rdata_idle_chk
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == 32'b0));

  // R12
  // bus_excl_chk
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

endmodule

// File: tb/fb_regif_tb.sv
`timescale 1ns/1ps
module fb_regif_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_done = 1'b0;
  logic        irq;
  logic [11:0] disp_width, disp_height;
  logic        disp_blank, cursor_off, image_on;
  logic [4:0]  depth_bits;
  logic [22:0] screen_top;
  logic [11:0] cursor_x, cursor_y;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic [8:0]  curpat_idx = '0;
  logic [15:0] curpat_word;
  logic [71:0] curpal_rgb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fb_regif u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done), .irq(irq),
    .disp_width(disp_width), .disp_height(disp_height), .disp_blank(disp_blank),
    .cursor_off(cursor_off), .depth_bits(depth_bits), .image_on(image_on),
    .screen_top(screen_top), .cursor_x(cursor_x), .cursor_y(cursor_y),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb), .curpat_idx(curpat_idx),
    .curpat_word(curpat_word), .curpal_rgb(curpal_rgb)
  );

  // {is_read, requirement number, byte offset, write data or expected read}
  localparam int NV = 31;
  localparam logic [57:0] VEC [NV] = '{
    {1'b0, 4'd2,  21'h000150, 32'h0000_0003},
    {1'b1, 4'd2,  21'h000150, 32'h0000_0002},  // R2 odd value reads back even
    {1'b0, 4'd1,  21'h000118, 32'h0000_0050},
    {1'b1, 4'd1,  21'h000118, 32'h0000_0050},  // R1
    {1'b0, 4'd2,  21'h000150, 32'h0000_0101},
    {1'b1, 4'd2,  21'h000150, 32'h0000_0100},  // R2
    {1'b0, 4'd3,  21'h000300, 32'h00B0_0400},
    {1'b1, 4'd3,  21'h000300, 32'h00B0_0400},  // R3
    {1'b0, 4'd6,  21'h000508, 32'h0011_2233},
    {1'b0, 4'd6,  21'h000510, 32'h0044_5566},
    {1'b0, 4'd6,  21'h000518, 32'h0077_8899},
    {1'b1, 4'd6,  21'h000508, 32'h0011_2233},  // R6
    {1'b1, 4'd6,  21'h000518, 32'h0077_8899},  // R6 last entry
    {1'b0, 4'd7,  21'h001008, 32'h0000_ABCD},
    {1'b1, 4'd7,  21'h001008, 32'h0000_ABCD},  // R7
    {1'b0, 4'd7,  21'h001FF8, 32'h0000_1234},
    {1'b1, 4'd7,  21'h001FF8, 32'h0000_1234},  // R7 last slot
    {1'b0, 4'd7,  21'h001000, 32'hFFFF_5A5A},
    {1'b1, 4'd7,  21'h001000, 32'h0000_5A5A},  // R7 upper bits dropped
    {1'b0, 4'd5,  21'h000800, 32'h00FF_0000},
    {1'b1, 4'd5,  21'h000800, 32'h0000_0000},  // R5 write-only
    {1'b0, 4'd8,  21'h000400, 32'h1234_5678},
    {1'b1, 4'd8,  21'h000400, 32'h0000_0000},  // R8
    {1'b0, 4'd8,  21'h000638, 32'h00AB_C123},
    {1'b1, 4'd8,  21'h000638, 32'h0000_0000},  // R8
    {1'b0, 4'd9,  21'h000120, 32'h0000_DEAD},  // R9 timing offset
    {1'b0, 4'd9,  21'h000200, 32'h0000_BEEF},  // R9 timing offset
    {1'b0, 4'd9,  21'h0007FC, 32'h0000_0001},  // R9 unmapped
    {1'b1, 4'd9,  21'h000118, 32'h0000_0050},  // R9 width kept
    {1'b1, 4'd9,  21'h0007FC, 32'h0000_0000},  // R9 unmapped read
    {1'b1, 4'd7,  21'h001008, 32'h0000_ABCD}   // R7 still held
  };

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [20:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10", disp_width, 0);
    check("R10", disp_height, 0);
    check("R11", irq, 0);
    check("R12", bus_rdata, 0);
    check("R10", pix_rgb, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][57]) begin
        bus_read(VEC[i][52:32], rd);
        check($sformatf("R%0d vec%0d", VEC[i][56:53], i), rd, VEC[i][31:0]);
      end else begin
        bus_write(VEC[i][52:32], VEC[i][31:0]);
      end
    end

    // R12 data drops to zero the cycle after a read
    @(negedge clk);
    check("R12", bus_rdata, 0);

    check("R1", disp_width, 12'h140);
    check("R2", disp_height, 12'h080);
    check("R3", disp_blank, 1);
    check("R3", cursor_off, 1);
    check("R4", image_on, 0);
    check("R8", screen_top, 23'h345678);
    check("R8", cursor_x, 12'hABC);
    check("R8", cursor_y, 12'h123);
    check("R6", curpal_rgb[47:24], 24'h445566);
    check("R6", curpal_rgb[71:48], 24'h778899);

    // R4 depth code table
    for (int c = 0; c < 8; c++) begin
      logic [4:0] expd;
      case (c)
        0: expd = 1; 1: expd = 2; 2: expd = 4; 3: expd = 8;
        4: expd = 15; 5: expd = 16; default: expd = 0;
      endcase
      bus_write(21'h300, 32'(c) << 20);
      check("R4", depth_bits, expd);
      check("R4", image_on, (c == 3));
    end
    bus_write(21'h300, 32'h0030_0400);
    check("R4", image_on, 0);
    check("R3", disp_blank, 1);

    // R5 pixel port lookups
    bus_write(21'h828, 32'h000A_0B0C);
    bus_write(21'hFF8, 32'h0010_2030);
    @(negedge clk); pix_idx = 8'd5;
    @(negedge clk); check("R5", pix_rgb, 24'h0A0B0C);
    pix_idx = 8'd255;
    @(negedge clk); check("R5", pix_rgb, 24'h102030);
    pix_idx = 8'd0;
    @(negedge clk); check("R5", pix_rgb, 24'hFF0000);
    pix_idx = 8'd6;
    @(negedge clk); check("R5", pix_rgb, 24'h0);

    // R7 pattern port lookups
    curpat_idx = 9'd511;
    @(negedge clk); check("R7", curpat_word, 16'h1234);
    curpat_idx = 9'd1;
    @(negedge clk); check("R7", curpat_word, 16'hABCD);
    curpat_idx = 9'd2;
    @(negedge clk); check("R7", curpat_word, 16'h0);

    // R11 interrupt
    frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    check("R11", irq, 1);
    bus_write(21'h108, 32'h1);
    check("R11", irq, 0);
    @(negedge clk);
    frame_done = 1'b1; bus_wr = 1'b1; bus_addr = 21'h108; bus_wdata = 32'h0;
    @(negedge clk);
    frame_done = 1'b0; bus_wr = 1'b0;
    check("R11", irq, 1);

    // R10 soft reset
    bus_write(21'h100000, 32'hFFFF_FFFF);
    check("R10", irq, 0);
    check("R10", disp_width, 0);
    check("R10", disp_height, 0);
    check("R10", screen_top, 0);
    check("R10", {cursor_x, cursor_y}, 0);
    check("R10", curpal_rgb, 0);
    bus_read(21'h300, rd);  check("R10", rd, 0);
    bus_read(21'h510, rd);  check("R10", rd, 0);
    bus_read(21'h1FF8, rd); check("R10", rd, 0);
    pix_idx = 8'd5;
    @(negedge clk); @(negedge clk);
    check("R10", pix_rgb, 0);
    bus_write(21'h828, 32'h0077_7777);
    @(negedge clk);
    check("R10", pix_rgb, 24'h777777);

    done = 1;
    finish_run();
  end

endmodule